// File: doc/BRIEF.md
# Serial Flash Command Header Framer

This block assembles the opening portion of a serial flash transaction: the opcode, an optional address and a number of dummy bytes. All of them are sent on one lane. On each request strobe it takes an opcode, a 32-bit address value, an address length, a dummy byte count, a data byte count and a data lane code. It registers an 8-byte command buffer, presented as two 32-bit words. It also registers the number of single-lane header clock cycles and the number of data-phase clock cycles that a downstream transmit engine has to run.

Each byte of the buffer has a fixed slot position. Slot 3 always carries the opcode. The address bytes fill the slots below it. Filler slots carry 0xFF, and slots that a mode does not use read as 0x00. With a 4-byte address, the slot that holds the lowest address byte depends on whether dummy bytes follow. A request with an address length or a lane code outside the accepted set raises an error flag in place of a header.

Top module: `flash_hdr_framer`

## Requirements
- R1: While reset is held and after its release, before any request: out_valid, cfg_err, both command words, hdr_cycles and data_cycles are all zero.
- R2: out_valid is high for exactly the one cycle after each cycle with req_valid high. All outputs keep their values in cycles with no request.
- R3: Slot k (k = 0..3) is bits 8k+7:8k of cmd_word0. Slot k (k = 4..7) is bits 8(k-4)+7:8(k-4) of cmd_word1. With addr_len 0 (no address), slot 3 = opcode, slot 2 = 0xFF, and all other slots = 0x00.
- R4: With addr_len 3: slot 3 = opcode, slot 2 = addr[23:16], slot 1 = addr[15:8], slot 0 = addr[7:0], slots 7 and 6 = 0xFF, slots 5 and 4 = 0x00.
- R5: With addr_len 4 and a nonzero dummy count: slot 3 = opcode, slot 2 = addr[31:24], slot 1 = addr[23:16], slot 0 = addr[15:8], slot 7 = addr[7:0], slot 6 = 0xFF, slots 5 and 4 = 0x00.
- R6: With addr_len 4 and a dummy count of zero, the layout is the same as in R5 except that addr[7:0] is in slot 4 and slot 7 = 0x00.
- R7: hdr_cycles = 8, 32 or 40 for addr_len 0, 3 or 4 respectively, plus 8 times the dummy byte count.
- R8: Any addr_len other than 0, 3 or 4 sets cfg_err. When cfg_err is set, both words, hdr_cycles and data_cycles are zero.
- R9: data_cycles = data_bytes * 8 / lanes, where lane_code 0, 1 and 2 select 1, 2 and 4 lanes.
- R10: lane_code 3 sets cfg_err, with the same zeroed outputs as in R8, even when the address length is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per header |
| opcode | input | 8 | Command opcode |
| addr | input | 32 | Address value |
| addr_len | input | 3 | Address length in bytes (0, 3 or 4 accepted) |
| dummy_cnt | input | DUMMY_W (4) | Dummy byte count |
| data_bytes | input | NB_W (16) | Data phase byte count |
| lane_code | input | 2 | Data lanes: 0=1, 1=2, 2=4, 3=invalid |
| out_valid | output | 1 | Outputs updated this cycle |
| cmd_word0 | output | 32 | Slots 3..0, slot 3 in the top byte |
| cmd_word1 | output | 32 | Slots 7..4, slot 7 in the top byte |
| hdr_cycles | output | CYC_W (8) | Single-lane header cycle count |
| data_cycles | output | NB_W+3 (19) | Data phase cycle count |
| cfg_err | output | 1 | Unsupported address length or lane code |

## Verification
An error in the mode decode or the slot muxing shows at the ports in the single result cycle that follows the strobe: a byte sits in the wrong slot of a command word, or a filler byte differs from 0xFF or 0x00. The 4-byte cases with and without dummy bytes are the main targets, because only there does the low address byte move. An error in the cycle arithmetic shows in the same cycle as a wrong hdr_cycles or data_cycles value. A fault in the hold logic only shows in the idle cycles after a result, so the outputs are also compared in those cycles.

// File: rtl/flash_hdr_pkg.sv
package flash_hdr_pkg;

    typedef enum logic [1:0] {
        AM_NONE = 2'd0,
        AM_A24  = 2'd1,
        AM_A32  = 2'd2,
        AM_BAD  = 2'd3
    } addr_mode_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

    function automatic addr_mode_e decode_len(input logic [2:0] len);
        case (len)
            3'd0:    decode_len = AM_NONE;
            3'd3:    decode_len = AM_A24;
            3'd4:    decode_len = AM_A32;
            default: decode_len = AM_BAD;
        endcase
    endfunction

endpackage

// File: rtl/hdr_slot_pack.sv
module hdr_slot_pack
    import flash_hdr_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  addr_mode_e  mode,
    input  logic [7:0]  opcode,
    input  logic [31:0] addr,
    input  logic        has_dummy,
    output logic [31:0] word0,
    output logic [31:0] word1
);
    localparam int HALF = SLOTS / 2;

    logic [7:0] slot [SLOTS];

    always_comb begin
        for (int k = 0; k < SLOTS; k++) slot[k] = 8'h00;
        case (mode)
            AM_NONE: begin
                slot[3] = opcode;
                slot[2] = FILL_BYTE;
            end
            AM_A24: begin
                slot[3] = opcode;
                slot[2] = addr[23:16];
                slot[1] = addr[15:8];
                slot[0] = addr[7:0];
                slot[7] = FILL_BYTE;
                slot[6] = FILL_BYTE;
            end
            AM_A32: begin
                slot[3] = opcode;
                slot[2] = addr[31:24];
                slot[1] = addr[23:16];
                slot[0] = addr[15:8];
                slot[6] = FILL_BYTE;
                if (has_dummy) slot[7] = addr[7:0];
                else           slot[4] = addr[7:0];
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < HALF; g++) begin : g_pack
        assign word0[8*g +: 8] = slot[g];
        assign word1[8*g +: 8] = slot[g + HALF];
    end
endmodule

// File: rtl/hdr_cycle_calc.sv
module hdr_cycle_calc
    import flash_hdr_pkg::*;
#(
    parameter int DUMMY_W = 4,
    parameter int CYC_W   = 8,
    parameter int NB_W    = 16,
    parameter int DCYC_W  = NB_W + 3
) (
    input  addr_mode_e          mode,
    input  logic [DUMMY_W-1:0]  dummy_cnt,
    input  logic [NB_W-1:0]     data_bytes,
    input  logic [1:0]          lane_code,
    output logic [CYC_W-1:0]    hdr_cycles,
    output logic [DCYC_W-1:0]   data_cycles,
    output logic                lane_bad
);
    logic [CYC_W-1:0]  base_cyc;
    logic [CYC_W-1:0]  dummy_cyc;
    logic [DCYC_W-1:0] bit_cnt;

    always_comb begin
        case (mode)
            AM_NONE: base_cyc = CYC_W'(8);
            AM_A24:  base_cyc = CYC_W'(32);
            AM_A32:  base_cyc = CYC_W'(40);
            default: base_cyc = '0;
        endcase
        dummy_cyc   = CYC_W'(dummy_cnt) << 3;
        hdr_cycles  = base_cyc + dummy_cyc;
        bit_cnt     = DCYC_W'(data_bytes) << 3;
        lane_bad    = (lane_code == 2'd3);
        data_cycles = bit_cnt >> lane_code;
    end
endmodule

// File: rtl/flash_hdr_framer.sv
module flash_hdr_framer
    import flash_hdr_pkg::*;
#(
    parameter int DUMMY_W = 4,
    parameter int CYC_W   = 8,
    parameter int NB_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [7:0]          opcode,
    input  logic [31:0]         addr,
    input  logic [2:0]          addr_len,
    input  logic [DUMMY_W-1:0]  dummy_cnt,
    input  logic [NB_W-1:0]     data_bytes,
    input  logic [1:0]          lane_code,
    output logic                out_valid,
    output logic [31:0]         cmd_word0,
    output logic [31:0]         cmd_word1,
    output logic [CYC_W-1:0]    hdr_cycles,
    output logic [NB_W+2:0]     data_cycles,
    output logic                cfg_err
);
    localparam int DCYC_W = NB_W + 3;

    typedef struct packed {
        logic              vld;
        logic [31:0]       w0;
        logic [31:0]       w1;
        logic [CYC_W-1:0]  hc;
        logic [DCYC_W-1:0] dc;
        logic              err;
    } hdr_state_t;

    hdr_state_t state_d, state_q;

    addr_mode_e        mode;
    logic [31:0]       pk_w0, pk_w1;
    logic [CYC_W-1:0]  calc_hc;
    logic [DCYC_W-1:0] calc_dc;
    logic              lane_bad;

    assign mode = decode_len(addr_len);

    hdr_slot_pack #(.SLOTS(8)) u_pack (
        .mode      (mode),
        .opcode    (opcode),
        .addr      (addr),
        .has_dummy (dummy_cnt != '0),
        .word0     (pk_w0),
        .word1     (pk_w1)
    );

    hdr_cycle_calc #(
        .DUMMY_W (DUMMY_W),
        .CYC_W   (CYC_W),
        .NB_W    (NB_W),
        .DCYC_W  (DCYC_W)
    ) u_calc (
        .mode        (mode),
        .dummy_cnt   (dummy_cnt),
        .data_bytes  (data_bytes),
        .lane_code   (lane_code),
        .hdr_cycles  (calc_hc),
        .data_cycles (calc_dc),
        .lane_bad    (lane_bad)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = req_valid;
        if (req_valid) begin
            if (mode == AM_BAD || lane_bad) begin
                state_d.err = 1'b1;
                state_d.w0  = '0;
                state_d.w1  = '0;
                state_d.hc  = '0;
                state_d.dc  = '0;
            end else begin
                state_d.err = 1'b0;
                state_d.w0  = pk_w0;
                state_d.w1  = pk_w1;
                state_d.hc  = calc_hc;
                state_d.dc  = calc_dc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.vld;
    assign cmd_word0   = state_q.w0;
    assign cmd_word1   = state_q.w1;
    assign hdr_cycles  = state_q.hc;
    assign data_cycles = state_q.dc;
    assign cfg_err     = state_q.err;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(cmd_word0) && $stable(cmd_word1) && $stable(hdr_cycles)));
    a_r8_err_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_err) |-> (cmd_word0 == 32'd0 && cmd_word1 == 32'd0
                                    && hdr_cycles == '0 && data_cycles == '0));
    a_r7_cycle_align: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_err) |-> (hdr_cycles[2:0] == 3'd0 && hdr_cycles >= CYC_W'(8)));
    a_r3_opcode_slot: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (cfg_err || cmd_word0[31:24] == $past(opcode)));
    a_r10_lane_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lane_code == 2'd3) |=> cfg_err);
endmodule

// File: tb/flash_hdr_framer_test.sv
module flash_hdr_framer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [31:0] addr = '0;
    logic [2:0]  addr_len = '0;
    logic [3:0]  dummy_cnt = '0;
    logic [15:0] data_bytes = '0;
    logic [1:0]  lane_code = '0;
    logic        out_valid;
    logic [31:0] cmd_word0, cmd_word1;
    logic [7:0]  hdr_cycles;
    logic [18:0] data_cycles;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    flash_hdr_framer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
        .addr(addr), .addr_len(addr_len), .dummy_cnt(dummy_cnt),
        .data_bytes(data_bytes), .lane_code(lane_code), .out_valid(out_valid),
        .cmd_word0(cmd_word0), .cmd_word1(cmd_word1), .hdr_cycles(hdr_cycles),
        .data_cycles(data_cycles), .cfg_err(cfg_err)
    );

    logic [31:0] e_w0, e_w1;
    logic [7:0]  e_hc;
    logic [18:0] e_dc;
    logic        e_err;

    function automatic void model(input logic [7:0] op, input logic [31:0] a,
                                  input logic [2:0] len, input logic [3:0] dm,
                                  input logic [15:0] nb, input logic [1:0] lc);
        logic [7:0] s [8];
        for (int k = 0; k < 8; k++) s[k] = 8'h00;
        e_err = (len != 3'd0 && len != 3'd3 && len != 3'd4) || lc == 2'd3;
        e_hc = 8'd0;
        if (len == 3'd0) begin
            s[3] = op; s[2] = 8'hFF; e_hc = 8'd8;
        end else if (len == 3'd3) begin
            s[3] = op; s[2] = a[23:16]; s[1] = a[15:8]; s[0] = a[7:0];
            s[7] = 8'hFF; s[6] = 8'hFF; e_hc = 8'd32;
        end else if (len == 3'd4) begin
            s[3] = op; s[2] = a[31:24]; s[1] = a[23:16]; s[0] = a[15:8];
            s[6] = 8'hFF; e_hc = 8'd40;
            if (dm != 0) s[7] = a[7:0]; else s[4] = a[7:0];
        end
        e_hc = e_hc + 8'(dm) * 8'd8;
        e_dc = 19'((int'(nb) * 8) / (1 << lc));
        e_w0 = {s[3], s[2], s[1], s[0]};
        e_w1 = {s[7], s[6], s[5], s[4]};
        if (e_err) begin
            e_w0 = '0; e_w1 = '0; e_hc = '0; e_dc = '0;
        end
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [7:0] op, input logic [31:0] a,
                           input logic [2:0] len, input logic [3:0] dm,
                           input logic [15:0] nb, input logic [1:0] lc);
        @(negedge clk);
        req_valid = 1'b1; opcode = op; addr = a; addr_len = len;
        dummy_cnt = dm; data_bytes = nb; lane_code = lc;
        model(op, a, len, dm, nb, lc);
        @(negedge clk);
        req_valid = 1'b0; opcode = ~op; addr = ~a;
        check({req, " valid R2"}, 128'(out_valid), 128'(1));
        check({req, " words"}, 128'({cmd_word1, cmd_word0}), 128'({e_w1, e_w0}));
        check({req, " hdr_cycles R7"}, 128'(hdr_cycles), 128'(e_hc));
        check({req, " data_cycles R9"}, 128'(data_cycles), 128'(e_dc));
        check({req, " err R8"}, 128'(cfg_err), 128'(e_err));
        @(negedge clk);
        check({req, " hold R2"}, 128'({out_valid, cmd_word1, cmd_word0, hdr_cycles}),
              128'({1'b0, e_w1, e_w0, e_hc}));
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset", 128'({out_valid, cfg_err, cmd_word0, cmd_word1, hdr_cycles, data_cycles}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 128'({out_valid, cmd_word0, cmd_word1, hdr_cycles}), 128'(0));

        run_one("R3 no addr", 8'h9F, 32'h12345678, 3'd0, 4'd0, 16'd4, 2'd0);
        run_one("R3 no addr dummy", 8'h5A, 32'hDEADBEEF, 3'd0, 4'd2, 16'd3, 2'd1);
        run_one("R4 a24", 8'h03, 32'hAABBCCDD, 3'd3, 4'd0, 16'd256, 2'd2);
        run_one("R4 a24 dummy", 8'h0B, 32'h00123456, 3'd3, 4'd1, 16'd100, 2'd0);
        run_one("R5 a32 dummy", 8'h6C, 32'h11223344, 3'd4, 4'd3, 16'd16, 2'd2);
        run_one("R6 a32 no dummy", 8'h13, 32'h55667788, 3'd4, 4'd0, 16'd1, 2'd0);
        run_one("R7 max dummy", 8'hEB, 32'h01020304, 3'd4, 4'd15, 16'hFFFF, 2'd2);
        run_one("R8 len1", 8'h02, 32'hFFFFFFFF, 3'd1, 4'd1, 16'd8, 2'd0);
        run_one("R8 len7", 8'h02, 32'hCAFEF00D, 3'd7, 4'd0, 16'd8, 2'd1);
        run_one("R10 lane3", 8'h6B, 32'h01234567, 3'd3, 4'd1, 16'd64, 2'd3);
        run_one("R9 zero bytes", 8'h05, 32'h0, 3'd0, 4'd0, 16'd0, 2'd1);

        for (int i = 0; i < 300; i++) begin
            logic [2:0] l;
            int pick;
            pick = $urandom_range(0, 9);
            l = (pick < 3) ? 3'd0 : (pick < 6) ? 3'd3 : (pick < 9) ? 3'd4 : 3'($urandom_range(0, 7));
            run_one("random R3 R4 R5 R6", 8'($urandom), $urandom, l, 4'($urandom_range(0, 15)),
                    16'($urandom), 2'($urandom_range(0, 3)));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule